// File: doc/BRIEF.md
# Upper-Level-Aware LRU Victim Selector

This block chooses which way of one set in a shared, inclusive last-level cache is evicted when a new line must be brought in. It keeps a full recency order over the ways of the set. For each way it also keeps a valid bit and a "live above" flag. The flag tells whether some upper-level cache currently holds and uses that line. Evicting a line that is live above would force the upper cache to drop useful data, so the selector walks the recency order from oldest to newest and takes the first way that no upper cache is using. Only when every way is live above does it fall back to the plain oldest way. Empty ways are always taken first.

The cache controller reports each lookup hit and each fill on the access port. Upper-level caches report, on the hint port, when they start or stop using a line. A one-cycle replacement request yields, one cycle later, a one-cycle victim pulse carrying the way index and a back-invalidate strobe. The strobe tells the hierarchy that the upper-level copies of that line must be removed. Requests are always accepted and the victim pulse cannot be stalled: the block has no back-pressure. A caller that cannot take a victim in a given cycle must not request one.

Top module: `llc_victim_sel`

## Requirements
- R1: While reset is held and in the first cycle after it, `vict_valid` and `vict_binv` are 0. Reset leaves every way empty with its live flag clear, and sets the recency order from way 0 (newest) to way WAYS-1 (oldest).
- R2: If any way is empty, the victim is the empty way with the lowest index, whatever the recency order and live flags.
- R3: If all ways hold lines, the victim is the oldest way whose live flag is clear.
- R4: If all ways hold lines and every live flag is set, the victim is the oldest way.
- R5: A hit or fill on `acc_way` makes that way the newest. Ways that were newer than it each become one step older. The relative order of all other ways is unchanged.
- R6: A fill (`acc_fill`=1) marks the way as holding a line. It sets the way's live flag when `acc_upper`=1 and clears it when `acc_upper`=0.
- R7: A hint sets the live flag of `hint_way` when `hint_live`=1 and clears it when `hint_live`=0.
- R8: `vict_valid` pulses for exactly one cycle, in the cycle after each cycle with `repl_req`=1. `vict_binv` is 1 in that cycle exactly when the chosen way held a line, and it is never 1 without `vict_valid`.
- R9: A back-invalidate clears the victim's live flag. When a hint to the same way arrives in the request cycle, the clear wins over the hint.
- R10: When a hint and an access name the same way in the same cycle, both take effect: the live flag follows the hint and the recency follows the access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | Hit or fill on this set in this cycle |
| acc_way | input | $clog2(WAYS) | Way touched by the access |
| acc_fill | input | 1 | The access is a fill of a new line |
| acc_upper | input | 1 | The fill serves an upper-level request (live above) |
| hint_valid | input | 1 | Upper-level usage hint present |
| hint_way | input | $clog2(WAYS) | Way the hint refers to |
| hint_live | input | 1 | 1: an upper cache now uses the line, 0: it no longer does |
| repl_req | input | 1 | Request to choose a victim |
| vict_valid | output | 1 | Victim pulse, one cycle after the request |
| vict_way | output | $clog2(WAYS) | Chosen victim way |
| vict_binv | output | 1 | Back-invalidate the upper-level copies of the victim |

## Verification
The hardest cases to reach are the ones where hint, access and replacement events coincide on one way. One such case is a hint that tries to mark the chosen victim live in the very cycle its flag is being cleared. Another is a hint and a hit on one way in the same cycle. From the ports, a dropped flag update or recency update looks like a normal choice unless the set is first placed in a state where exactly one way is not live. The bench therefore builds a fully valid set through a fixed fill order, then drives hints until a single way stays clear, and fires the coincident events on that way. A wrong merge then changes the next victim from the expected way to the oldest one.

// File: rtl/llc_vsel_pkg.sv
package llc_vsel_pkg;

  // Which rule produced the victim of the current cycle.
  typedef enum logic [1:0] {
    SRC_EMPTY    = 2'd0,
    SRC_IDLE_OLD = 2'd1,
    SRC_FALLBACK = 2'd2
  } vsel_src_e;

endpackage

// File: rtl/llc_vsel_recency.sv
module llc_vsel_recency #(
  parameter int WAYS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          touch_en,
  input  logic [$clog2(WAYS)-1:0]       touch_way,
  output logic [WAYS*$clog2(WAYS)-1:0]  rank_flat
);
  localparam int WAY_W = $clog2(WAYS);

  // Rank 0 is newest, rank WAYS-1 is oldest.
  logic [WAY_W-1:0] rank_q [WAYS];
  logic [WAY_W-1:0] touched_rank;

  assign touched_rank = rank_q[touch_way];

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rank_q[g] <= WAY_W'(g);
      end else if (touch_en) begin
        if (touch_way == WAY_W'(g)) begin
          rank_q[g] <= '0;
        end else if (rank_q[g] < touched_rank) begin
          rank_q[g] <= rank_q[g] + WAY_W'(1);
        end
      end
    end
    assign rank_flat[g*WAY_W +: WAY_W] = rank_q[g];
  end

endmodule

// File: rtl/llc_vsel_flags.sv
module llc_vsel_flags #(
  parameter int WAYS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fill_en,
  input  logic [$clog2(WAYS)-1:0] fill_way,
  input  logic                    fill_upper,
  input  logic                    hint_en,
  input  logic [$clog2(WAYS)-1:0] hint_way,
  input  logic                    hint_live,
  input  logic                    binv_en,
  input  logic [$clog2(WAYS)-1:0] binv_way,
  output logic [WAYS-1:0]         valid_vec,
  output logic [WAYS-1:0]         live_vec
);
  localparam int WAY_W = $clog2(WAYS);

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    logic fill_hit, hint_hit, binv_hit;

    assign fill_hit = fill_en && (fill_way == WAY_W'(g));
    assign hint_hit = hint_en && (hint_way == WAY_W'(g));
    assign binv_hit = binv_en && (binv_way == WAY_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_vec[g] <= 1'b0;
      end else if (fill_hit) begin
        valid_vec[g] <= 1'b1;
      end
    end

    // Priority: eviction clear, then upper-level hint, then fill.
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        live_vec[g] <= 1'b0;
      end else if (binv_hit) begin
        live_vec[g] <= 1'b0;
      end else if (hint_hit) begin
        live_vec[g] <= hint_live;
      end else if (fill_hit) begin
        live_vec[g] <= fill_upper;
      end
    end
  end

endmodule

// File: rtl/llc_vsel_picker.sv
module llc_vsel_picker
  import llc_vsel_pkg::*;
#(
  parameter int WAYS = 8
) (
  input  logic [WAYS*$clog2(WAYS)-1:0] rank_flat,
  input  logic [WAYS-1:0]              valid_vec,
  input  logic [WAYS-1:0]              live_vec,
  output logic [$clog2(WAYS)-1:0]      pick_way,
  output logic                         pick_valid,
  output vsel_src_e                    pick_src
);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAY_W-1:0] way_at_rank [WAYS];
  logic             empty_found;
  logic [WAY_W-1:0] empty_way;
  logic             idle_found;
  logic [WAY_W-1:0] idle_way;

  // Invert the rank table: which way sits at each age position.
  always_comb begin
    for (int p = 0; p < WAYS; p++) way_at_rank[p] = '0;
    for (int w = 0; w < WAYS; w++) begin
      way_at_rank[rank_flat[w*WAY_W +: WAY_W]] = WAY_W'(w);
    end
  end

  // Lowest-index empty way.
  always_comb begin
    empty_found = 1'b0;
    empty_way   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_vec[w]) begin
        empty_found = 1'b1;
        empty_way   = WAY_W'(w);
      end
    end
  end

  // Oldest way that no upper cache is using; later positions override.
  always_comb begin
    idle_found = 1'b0;
    idle_way   = '0;
    for (int p = 0; p < WAYS; p++) begin
      if (!live_vec[way_at_rank[p]]) begin
        idle_found = 1'b1;
        idle_way   = way_at_rank[p];
      end
    end
  end

  always_comb begin
    if (empty_found) begin
      pick_src = SRC_EMPTY;
      pick_way = empty_way;
    end else if (idle_found) begin
      pick_src = SRC_IDLE_OLD;
      pick_way = idle_way;
    end else begin
      pick_src = SRC_FALLBACK;
      pick_way = way_at_rank[WAYS-1];
    end
  end

  assign pick_valid = valid_vec[pick_way];

endmodule

// File: rtl/llc_victim_sel.sv
module llc_victim_sel
  import llc_vsel_pkg::*;
#(
  parameter int WAYS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_valid,
  input  logic [$clog2(WAYS)-1:0] acc_way,
  input  logic                    acc_fill,
  input  logic                    acc_upper,
  input  logic                    hint_valid,
  input  logic [$clog2(WAYS)-1:0] hint_way,
  input  logic                    hint_live,
  input  logic                    repl_req,
  output logic                    vict_valid,
  output logic [$clog2(WAYS)-1:0] vict_way,
  output logic                    vict_binv
);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS*WAY_W-1:0] rank_flat;
  logic [WAYS-1:0]       valid_vec;
  logic [WAYS-1:0]       live_vec;
  logic [WAY_W-1:0]      pick_way;
  logic                  pick_valid;
  vsel_src_e             pick_src;
  logic                  binv_en;

  assign binv_en = repl_req && pick_valid;

  llc_vsel_recency #(.WAYS(WAYS)) u_recency (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (acc_valid),
    .touch_way (acc_way),
    .rank_flat (rank_flat)
  );

  llc_vsel_flags #(.WAYS(WAYS)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_en    (acc_valid && acc_fill),
    .fill_way   (acc_way),
    .fill_upper (acc_upper),
    .hint_en    (hint_valid),
    .hint_way   (hint_way),
    .hint_live  (hint_live),
    .binv_en    (binv_en),
    .binv_way   (pick_way),
    .valid_vec  (valid_vec),
    .live_vec   (live_vec)
  );

  llc_vsel_picker #(.WAYS(WAYS)) u_picker (
    .rank_flat  (rank_flat),
    .valid_vec  (valid_vec),
    .live_vec   (live_vec),
    .pick_way   (pick_way),
    .pick_valid (pick_valid),
    .pick_src   (pick_src)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vict_valid <= 1'b0;
      vict_way   <= '0;
      vict_binv  <= 1'b0;
    end else begin
      vict_valid <= repl_req;
      vict_binv  <= binv_en;
      if (repl_req) vict_way <= pick_way;
    end
  end

endmodule

// File: rtl/llc_vsel_checker.sv
module llc_vsel_checker #(
  parameter int WAYS = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         acc_valid,
  input logic [$clog2(WAYS)-1:0]      acc_way,
  input logic                         acc_fill,
  input logic                         repl_req,
  input logic                         vict_valid,
  input logic [$clog2(WAYS)-1:0]      vict_way,
  input logic                         vict_binv,
  input logic [WAYS*$clog2(WAYS)-1:0] rank_flat,
  input logic [WAYS-1:0]              valid_vec,
  input logic [WAYS-1:0]              live_vec
);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAY_W-1:0] acc_way_d;
  logic [WAYS-1:0]  valid_d;
  logic [WAY_W-1:0] rank_of_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_way_d <= '0;
      valid_d   <= '0;
    end else begin
      acc_way_d <= acc_way;
      valid_d   <= valid_vec;
    end
  end

  assign rank_of_prev = rank_flat[acc_way_d*WAY_W +: WAY_W];

  // R5: ranks always form a permutation of the ways.
  for (genvar p = 0; p < WAYS; p++) begin : g_perm
    logic [WAYS-1:0] holders;
    always_comb begin
      for (int w = 0; w < WAYS; w++)
        holders[w] = (rank_flat[w*WAY_W +: WAY_W] == WAY_W'(p));
    end
    assert_rank_perm_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(holders) == 1);
  end

  assert_touch_newest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (rank_of_prev == '0));

  assert_fill_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_fill) |=> valid_vec[acc_way_d]);

  assert_pulse_after_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    repl_req |=> vict_valid);

  assert_no_pulse_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !repl_req |=> !vict_valid);

  assert_strobe_in_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vict_binv |-> vict_valid);

  assert_strobe_iff_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vict_valid |-> (vict_binv == valid_d[vict_way]));

  assert_binv_clears_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vict_valid && vict_binv) |-> !live_vec[vict_way]);

endmodule

bind llc_victim_sel llc_vsel_checker #(.WAYS(WAYS)) u_vsel_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_way    (acc_way),
  .acc_fill   (acc_fill),
  .repl_req   (repl_req),
  .vict_valid (vict_valid),
  .vict_way   (vict_way),
  .vict_binv  (vict_binv),
  .rank_flat  (rank_flat),
  .valid_vec  (valid_vec),
  .live_vec   (live_vec)
);

// File: tb/tb_llc_victim_sel.sv
module tb_llc_victim_sel;
  localparam int CLK_PERIOD = 10;
  localparam int WAYS       = 8;
  localparam int WAY_W      = $clog2(WAYS);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             acc_valid = 1'b0;
  logic [WAY_W-1:0] acc_way = '0;
  logic             acc_fill = 1'b0;
  logic             acc_upper = 1'b0;
  logic             hint_valid = 1'b0;
  logic [WAY_W-1:0] hint_way = '0;
  logic             hint_live = 1'b0;
  logic             repl_req = 1'b0;
  logic             vict_valid;
  logic [WAY_W-1:0] vict_way;
  logic             vict_binv;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  llc_victim_sel #(.WAYS(WAYS)) dut (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_way(acc_way), .acc_fill(acc_fill), .acc_upper(acc_upper),
    .hint_valid(hint_valid), .hint_way(hint_way), .hint_live(hint_live),
    .repl_req(repl_req),
    .vict_valid(vict_valid), .vict_way(vict_way), .vict_binv(vict_binv)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One cycle of stimulus: drive after a falling edge, hold over the rising edge.
  task automatic step(bit av, int aw, bit af, bit au, bit hv, int hw, bit hl, bit rq);
    acc_valid = av; acc_way = WAY_W'(aw); acc_fill = af; acc_upper = au;
    hint_valid = hv; hint_way = WAY_W'(hw); hint_live = hl; repl_req = rq;
    @(negedge clk);
    acc_valid = 1'b0; acc_fill = 1'b0; acc_upper = 1'b0;
    hint_valid = 1'b0; hint_live = 1'b0; repl_req = 1'b0;
  endtask

  task automatic fill(int w, bit up);  step(1, w, 1, up, 0, 0, 0, 0); endtask
  task automatic touch(int w);         step(1, w, 0, 0, 0, 0, 0, 0); endtask
  task automatic hint(int w, bit live); step(0, 0, 0, 0, 1, w, live, 0); endtask

  task automatic expect_victim(string req, int w, bit binv);
    check({req, " vict_valid"}, int'(vict_valid), 1);
    check({req, " vict_way"}, int'(vict_way), w);
    check({req, " vict_binv"}, int'(vict_binv), int'(binv));
  endtask

  task automatic request(string req, int w, bit binv);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    expect_victim(req, w, binv);
  endtask

  task automatic t_reset();
    check("R1 reset vict_valid", int'(vict_valid), 0);
    check("R1 reset vict_binv", int'(vict_binv), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset vict_valid", int'(vict_valid), 0);
    request("R1 R2 empty set picks way 0", 0, 0);
    @(negedge clk);
    check("R8 pulse lasts one cycle", int'(vict_valid), 0);
    check("R8 no strobe after pulse", int'(vict_binv), 0);
  endtask

  // Fill order 0,2,1,3..7 -> oldest to newest 0,2,1,3,4,5,6,7.
  task automatic t_empty_first();
    fill(0, 0);
    fill(2, 0);
    request("R2 lowest empty way", 1, 0);
    fill(1, 0);
    for (int w = 3; w < WAYS; w++) fill(w, 0);
  endtask

  task automatic t_lru_order();
    request("R3 oldest way", 0, 1);
    touch(0);  // order 2,1,3,4,5,6,7,0
    request("R5 touched way becomes newest", 2, 1);
  endtask

  task automatic t_hints();
    hint(2, 1);
    hint(1, 1);
    request("R3 R7 skip live ways", 3, 1);
    hint(1, 0);
    request("R7 cleared hint makes way eligible", 1, 1);
  endtask

  task automatic t_fallback();
    for (int w = 0; w < WAYS; w++) hint(w, 1);
    request("R4 all live falls back to oldest", 2, 1);
    touch(2);  // order 1,3,4,5,6,7,0,2; only way 2 not live
    request("R9 strobe cleared live flag", 2, 1);
  endtask

  task automatic t_binv_race();
    step(0, 0, 0, 0, 1, 2, 1, 1);  // request and hint to the victim together
    expect_victim("R9 request with same-cycle hint", 2, 1);
    request("R9 clear wins over hint", 2, 1);
  endtask

  task automatic t_same_cycle();
    hint(1, 0);
    hint(2, 1);  // only way 1 not live, way 1 is oldest
    step(1, 1, 0, 0, 1, 1, 1, 0);  // order 3,4,5,6,7,0,2,1; all live
    request("R10 hint and access both applied", 3, 1);
  endtask

  task automatic t_fill_flag();
    fill(3, 1);  // order 4,5,6,7,0,2,1,3; all live
    request("R6 upper fill sets live", 4, 1);
    hint(4, 1);
    fill(5, 0);  // only way 5 not live, newest
    request("R6 plain fill clears live", 5, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_empty_first();
    t_lru_order();
    t_hints();
    t_fallback();
    t_binv_race();
    t_same_cycle();
    t_fill_flag();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule